// File: doc/BRIEF.md
# Segmented Memory Bus Interface

This block sits between an execution core and a simple synchronous memory. The core presents a request made of a 16-bit offset, a hint about where that offset came from, and optionally an explicit segment choice. The block picks one of four 16-bit segment values and forms a 20-bit physical byte address by multiplying the segment by sixteen and adding the offset. It then runs one or two bus cycles on a 16-bit data bus split into two byte lanes.

Even addresses use the low lane and odd addresses use the high lane. A word at an even address moves in one bus cycle. A word at an odd address is broken into two byte cycles, always taken in a fixed order. The block puts the two bytes back together on reads and spreads them across the two cycles on writes.

When the transfer is finished, the block gives a one-cycle completion strobe along with the read result. It accepts a new request only while it is idle.

Top module: `seg_bus_unit`

## Requirements
- R1: `mem_addr` equals (segment × 16 + offset) modulo 2^20, using the segment value captured when the request is accepted.
- R2: When `req_fetch` is 1, the code segment (`seg_cs`) is used. `req_ovr_valid`, `req_ovr_sel` and `req_bp_based` have no effect on the address in this case.
- R3: For a data access (`req_fetch`=0), the segment is chosen as follows. If `req_ovr_valid`=1, `req_ovr_sel` decides: 00 selects `seg_es`, 01 `seg_cs`, 10 `seg_ss`, 11 `seg_ds`. Otherwise, `req_bp_based`=1 selects `seg_ss`. Otherwise `seg_ds` is used.
- R4: A byte access runs one bus cycle. At an even address, `mem_be`=01 and the data moves on bits 7:0. At an odd address, `mem_be`=10 and the data moves on bits 15:8. Write data `req_wdata[7:0]` appears on both lanes. The read result is the addressed lane's byte, zero-extended into `rd_data[7:0]`.
- R5: A word access at an even address runs one bus cycle with `mem_be`=11. The least significant byte is on bits 7:0. Write data passes through unchanged, and `rd_data` equals `mem_rdata`.
- R6: A word access at an odd offset N runs two bus cycles, in this order:
  - First cycle: offset N, `mem_be`=10, carrying the low byte.
  - Second cycle: offset N+1 (wrapping within 16 bits), `mem_be`=01, carrying the high byte.
  - On writes, each byte appears on both lanes. On reads, `rd_data` = {second cycle bits 7:0, first cycle bits 15:8}.
- R7: While `mem_req` is 1 and `mem_ready` is 0, the block does not advance. `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values.
- R8: `req_ready` is 1 only while no bus cycle is pending. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and `mem_req` rises in the next cycle. `done` pulses high for exactly one cycle, in the cycle after the last bus cycle's `mem_ready`, and `rd_data` is valid in that same cycle.
- R9: After reset, `mem_req`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_fetch | input | 1 | Instruction fetch (code segment forced) |
| req_bp_based | input | 1 | Offset derived from the frame base register |
| req_ovr_valid | input | 1 | Explicit segment choice valid |
| req_ovr_sel | input | 2 | Explicit segment: 00 ES, 01 CS, 10 SS, 11 DS |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_offset | input | 16 | Offset within segment |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_be | output | 2 | Lane enables, bit 0 = bits 7:0 |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data |
| mem_ready | input | 1 | Memory completes current cycle |
| done | output | 1 | Access complete strobe |
| rd_data | output | 16 | Assembled read result |

## Verification
A request driven at one falling edge is taken at the next rising edge. The first bus cycle is checked at the falling edge that follows, and after every rising edge where `mem_ready` was held low, to confirm it held still. `mem_ready` is raised at a falling edge. The bench then expects one of two things at the next falling edge. For an odd word whose first half just completed, it expects the second bus cycle. Otherwise it expects `done` together with `rd_data`. Before each result, the bench counts every register on the path and samples only at the falling edge where that result is due.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FIRST  = 2'b01,
    ST_SECOND = 2'b10
  } bus_st_e;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import segbus_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             fetch,
  input  logic             bp_based,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] s_es,
  input  logic [SEG_W-1:0] s_cs,
  input  logic [SEG_W-1:0] s_ss,
  input  logic [SEG_W-1:0] s_ds,
  output logic [SEG_W-1:0] seg_val
);
  seg_sel_e sel;

  // Fetch wins over everything, then explicit choice, then base-register hint.
  always_comb begin
    if (fetch)          sel = SEG_CS;
    else if (ovr_valid) sel = seg_sel_e'(ovr_sel);
    else if (bp_based)  sel = SEG_SS;
    else                sel = SEG_DS;
  end

  always_comb begin
    unique case (sel)
      SEG_ES:  seg_val = s_es;
      SEG_CS:  seg_val = s_cs;
      SEG_SS:  seg_val = s_ss;
      default: seg_val = s_ds;
    endcase
  end
endmodule

// File: rtl/phys_addr_gen.sv
module phys_addr_gen #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int AW       = OFF_W + SEG_SHIFT
) (
  input  logic [OFF_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0]    phys
);
  logic [AW-1:0] seg_base;
  logic [AW-1:0] off_ext;

  assign seg_base = {seg, {SEG_SHIFT{1'b0}}};
  assign off_ext  = AW'(off);
  // Sum truncated to AW bits: wraps modulo 2^AW.
  assign phys     = seg_base + off_ext;
endmodule

// File: rtl/lane_unit.sv
module lane_unit #(
  parameter int LANE_W = 8,
  localparam int DW    = 2 * LANE_W
) (
  input  logic              full_word,
  input  logic              hi_half,
  input  logic              odd_lane,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     bus_wdata,
  output logic [LANE_W-1:0] lane_byte
);
  logic [LANE_W-1:0] wbyte;

  assign wbyte = hi_half ? wdata[DW-1:LANE_W] : wdata[LANE_W-1:0];

  // Single-byte transfers are copied onto both lanes; enables pick the live one.
  assign bus_wdata = full_word ? wdata : {wbyte, wbyte};
  assign lane_byte = odd_lane ? bus_rdata[DW-1:LANE_W] : bus_rdata[LANE_W-1:0];
endmodule

// File: rtl/seg_bus_unit.sv
module seg_bus_unit
  import segbus_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int LANE_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_fetch,
  input  logic                       req_bp_based,
  input  logic                       req_ovr_valid,
  input  logic [1:0]                 req_ovr_sel,
  input  logic                       req_write,
  input  logic                       req_word,
  input  logic [OFF_W-1:0]           req_offset,
  input  logic [2*LANE_W-1:0]        req_wdata,
  input  logic [OFF_W-1:0]           seg_es,
  input  logic [OFF_W-1:0]           seg_cs,
  input  logic [OFF_W-1:0]           seg_ss,
  input  logic [OFF_W-1:0]           seg_ds,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [OFF_W+SEG_SHIFT-1:0] mem_addr,
  output logic [1:0]                 mem_be,
  output logic [2*LANE_W-1:0]        mem_wdata,
  input  logic [2*LANE_W-1:0]        mem_rdata,
  input  logic                       mem_ready,
  output logic                       done,
  output logic [2*LANE_W-1:0]        rd_data
);
  localparam int DW = 2 * LANE_W;
  localparam int AW = OFF_W + SEG_SHIFT;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  bus_st_e           st_q, st_d;
  logic [OFF_W-1:0]  off_q, seg_q, seg_val, cur_off;
  logic              we_q, word_q;
  logic [DW-1:0]     wdata_q, rd_q, rd_d;
  logic [LANE_W-1:0] lo_q, lane_byte;
  logic              done_q;
  logic              accept, split, fin, capture_lo, word_even;

  seg_select #(.SEG_W(OFF_W)) u_sel (
    .fetch(req_fetch), .bp_based(req_bp_based), .ovr_valid(req_ovr_valid),
    .ovr_sel(req_ovr_sel), .s_es(seg_es), .s_cs(seg_cs), .s_ss(seg_ss),
    .s_ds(seg_ds), .seg_val(seg_val)
  );

  assign cur_off   = (st_q == ST_SECOND) ? off_q + OFF_W'(1) : off_q;
  assign split     = word_q & off_q[0];
  assign word_even = word_q & ~off_q[0];

  phys_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
    .seg(seg_q), .off(cur_off), .phys(mem_addr)
  );

  lane_unit #(.LANE_W(LANE_W)) u_lane (
    .full_word(word_even), .hi_half(st_q == ST_SECOND), .odd_lane(cur_off[0]),
    .wdata(wdata_q), .bus_rdata(mem_rdata), .bus_wdata(mem_wdata),
    .lane_byte(lane_byte)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = we_q & mem_req;

  always_comb begin
    if (st_q == ST_SECOND) mem_be = 2'b01;
    else if (word_even)    mem_be = 2'b11;
    else if (off_q[0])     mem_be = 2'b10;
    else                   mem_be = 2'b01;
  end

  // Next-state process
  always_comb begin
    st_d       = st_q;
    fin        = 1'b0;
    capture_lo = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = ST_FIRST;
      ST_FIRST:  if (mem_ready) begin
                   if (split) begin
                     st_d       = ST_SECOND;
                     capture_lo = 1'b1;
                   end else begin
                     st_d = ST_IDLE;
                     fin  = 1'b1;
                   end
                 end
      ST_SECOND: if (mem_ready) begin
                   st_d = ST_IDLE;
                   fin  = 1'b1;
                 end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (word_even)  rd_d = mem_rdata;
    else if (split) rd_d = {lane_byte, lo_q};
    else            rd_d = {{LANE_W{1'b0}}, lane_byte};
  end

  // Register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      off_q   <= '0;
      seg_q   <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
      rd_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (accept) begin
        off_q   <= req_offset;
        seg_q   <= seg_val;
        we_q    <= req_write;
        word_q  <= req_word;
        wdata_q <= req_wdata;
      end
      if (capture_lo) lo_q <= lane_byte;
      if (fin)        rd_q <= rd_d;
    end
  end

  assign done    = done_q;
  assign rd_data = rd_q;

  // Checks on the bus sequencing
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                 && $stable(mem_wdata) && $stable(mem_we)));

  p_split_order_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && mem_ready && word_q && mem_be == 2'b10 && st_q == ST_FIRST)
      |=> (mem_req && mem_be == 2'b01 && !mem_addr[0]));

  p_be_live_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> (mem_be != 2'b00));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(done) |-> $past(mem_req && mem_ready));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_ready) |=> mem_req);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> !mem_req);
endmodule

// File: tb/sim_seg_bus_unit.sv
module sim_seg_bus_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_fetch, req_bp_based, req_ovr_valid, req_write, req_word;
  logic [1:0]  req_ovr_sel;
  logic [15:0] req_offset, req_wdata;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        req_ready, mem_req, mem_we, mem_ready, done;
  logic [19:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata, rd_data;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  seg_bus_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fetch(req_fetch), .req_bp_based(req_bp_based),
    .req_ovr_valid(req_ovr_valid), .req_ovr_sel(req_ovr_sel),
    .req_write(req_write), .req_word(req_word), .req_offset(req_offset),
    .req_wdata(req_wdata), .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss),
    .seg_ds(seg_ds), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] pick_seg(input bit f, input bit bp, input bit ov,
                                           input logic [1:0] os);
    if (f) return seg_cs;
    if (ov) begin
      case (os)
        2'b00:   return seg_es;
        2'b01:   return seg_cs;
        2'b10:   return seg_ss;
        default: return seg_ds;
      endcase
    end
    if (bp) return seg_ss;
    return seg_ds;
  endfunction

  task automatic run(input bit f, input bit bp, input bit ov, input logic [1:0] os,
                     input bit wr, input bit wd, input logic [15:0] off,
                     input logic [15:0] wdat, input int waits);
    logic [15:0] sg, coff;
    logic [19:0] p, p1, p2;
    logic [1:0]  ebe;
    logic [15:0] ewd, erd;
    logic [7:0]  b;
    int          ncyc;
    string       arq, lrq;
    sg   = pick_seg(f, bp, ov, os);
    ncyc = (wd && off[0]) ? 2 : 1;
    arq  = f ? "R2" : ((ov || bp) ? "R3" : "R1");
    lrq  = (ncyc == 2) ? "R6" : (wd ? "R5" : "R4");
    p1   = 20'h0;
    p2   = 20'h0;
    @(negedge clk);
    chk("R8", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_fetch = f; req_bp_based = bp; req_ovr_valid = ov;
    req_ovr_sel = os; req_write = wr; req_word = wd; req_offset = off;
    req_wdata = wdat;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      coff = (c == 1) ? off + 16'd1 : off;
      p    = {sg, 4'h0} + {4'h0, coff};
      if (c == 0) p1 = p; else p2 = p;
      if (ncyc == 2) ebe = (c == 0) ? 2'b10 : 2'b01;
      else           ebe = wd ? 2'b11 : (off[0] ? 2'b10 : 2'b01);
      b   = (c == 1) ? wdat[15:8] : wdat[7:0];
      ewd = (wd && ncyc == 1) ? wdat : {b, b};
      for (int w = 0; w <= waits; w++) begin
        chk(w == 0 ? "R8" : "R7", {31'd0, mem_req}, 32'd1);
        chk(w == 0 ? arq : "R7", {12'd0, mem_addr}, {12'd0, p});
        chk(w == 0 ? lrq : "R7", {30'd0, mem_be}, {30'd0, ebe});
        chk("R7", {31'd0, mem_we}, {31'd0, wr});
        if (wr) chk(lrq, {16'd0, mem_wdata}, {16'd0, ewd});
        chk("R8", {31'd0, done}, 32'd0);
        if (w == waits) begin
          mem_ready = 1'b1;
          mem_rdata = {mbyte({p[19:1], 1'b1}), mbyte({p[19:1], 1'b0})};
        end
        @(posedge clk);
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = 16'hDEAD;
      end
    end
    chk("R8", {31'd0, done}, 32'd1);
    chk("R8", {31'd0, mem_req}, 32'd0);
    if (!wr) begin
      if (ncyc == 2) erd = {mbyte(p2), mbyte(p1)};
      else if (wd)   erd = {mbyte({p1[19:1], 1'b1}), mbyte(p1)};
      else           erd = {8'h00, mbyte(p1)};
      chk(lrq, {16'd0, rd_data}, {16'd0, erd});
    end
  endtask

  initial begin
    #(8 * 190000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] offs [8];
    offs = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
             16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    rst_n = 1'b0; req_valid = 1'b0; req_fetch = 1'b0; req_bp_based = 1'b0;
    req_ovr_valid = 1'b0; req_ovr_sel = 2'b00; req_write = 1'b0; req_word = 1'b0;
    req_offset = 16'h0; req_wdata = 16'h0; mem_ready = 1'b0; mem_rdata = 16'h0;
    seg_es = 16'hFFFF; seg_cs = 16'hF000; seg_ss = 16'h0B20; seg_ds = 16'h0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", {31'd0, mem_req}, 32'd0);
    chk("R9", {31'd0, done}, 32'd0);
    chk("R9", {31'd0, req_ready}, 32'd1);
    for (int m = 0; m < 8; m++) begin
      for (int o = 0; o < 8; o++) begin
        for (int k = 0; k < 4; k++) begin
          bit f, bp, ov;
          logic [1:0] os;
          f  = (m < 2);
          bp = (m == 1) || (m == 3) || (m == 5) || (m == 7);
          ov = (m == 1) || (m >= 4);
          os = (m == 1) ? 2'b10 : 2'(m - 4);
          run(f, bp, ov, os, k[0], k[1], offs[o],
              16'hA000 + 16'(m * 64 + o * 4 + k), (m + o + k) % 3);
        end
      end
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule